// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block runs the save and restore of program context for a 16-bit core that forms 20-bit physical addresses from a segment and an offset. When the core asks for an interrupt, the block takes an 8-bit type from one of three sources. These are an external device request, a software interrupt, or an internal exception. It saves the flags word, the code segment and the instruction pointer on the stack. It then reads the new instruction pointer and code segment from the vector table in the lowest kilobyte of memory. A return request restores those three words in the reverse order.

The block also serves three smaller requests. An overflow-check request enters vector 4 only when the overflow flag is set. The other two set or clear the interrupt-enable flag. It owns the CS, IP, SP and FLAGS registers, takes the stack segment from the core, and reaches memory through a single word-wide request/acknowledge port.

Top module: `irq_seq`

## Requirements
- R1: After reset, CS=1000h, IP=0040h, SP=0100h, FLAGS=0000h, busy and done are 0 and no memory request is raised.
- R2: For type n (0 to 255), the new IP is read from physical address 4n and the new CS from 4n+2, so every vector read falls in 00000h to 003FFh.
- R3: Entry writes the old FLAGS, then the old CS, then the old IP, at SS*16+SP-2, SS*16+SP-4 and SS*16+SP-6. Each push lowers SP by 2 before its write, so SP ends 6 lower.
- R4: Entry clears TF (bit 8) and IF (bit 9) after FLAGS has been pushed with their old values. All other flag bits keep their values.
- R5: A return reads IP from SS*16+SP, CS from SS*16+SP+2 and FLAGS from SS*16+SP+4. Each pop raises SP by 2 after its read.
- R6: A device request is taken only while IF=1, and otherwise causes no memory access and no change of state. Software and exception requests are taken whatever IF is.
- R7: An overflow-check request enters type 4 exactly when OF (bit 11) is 1. Otherwise it gives a done pulse with no memory access and no register change.
- R8: The set-IF and clear-IF requests change bit 9 of FLAGS only and then pulse done.
- R9: Requests are sampled only when idle. If several are raised at once, priority runs exception, software, overflow-check, return, set-IF, clear-IF, device.
- R10: done is high for exactly one cycle when a request completes, and at that point fetch_addr equals CS*16+IP of the new context.
- R11: At most one word access is outstanding. Address, direction and write data hold steady while mem_req is high and mem_ack low, and no request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stk_seg | input | 16 | Stack segment value from the core |
| hw_req | input | 1 | External device interrupt request |
| hw_type | input | 8 | Type supplied with the device request |
| sw_req | input | 1 | Software interrupt request |
| sw_type | input | 8 | Type given by the software interrupt |
| exc_req | input | 1 | Internal exception request |
| exc_type | input | 8 | Type of the internal exception |
| ovf_req | input | 1 | Overflow-check request |
| ret_req | input | 1 | Interrupt return request |
| seti_req | input | 1 | Set interrupt-enable flag |
| clri_req | input | 1 | Clear interrupt-enable flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes on this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_o | output | 16 | Code segment register |
| ip_o | output | 16 | Instruction pointer register |
| sp_o | output | 16 | Stack pointer register |
| flags_o | output | 16 | Flags register |
| fetch_addr | output | 20 | CS*16+IP physical fetch address |

## Verification
Entries are started from the software, device, overflow-check and exception sources, with vector types 0, 4, 50 and 255. Type 0 and type 255 confirm that both ends of the table give the right address. Type 50 confirms the C8h/CAh pair. Before some returns, the bench edits the stacked flags word to values carrying OF and TF. This shows that a return restores the stacked word and not the live flags, that the overflow check follows OF both ways, and that entry clears TF and IF without touching the rest. A device request with IF=0 and a burst of simultaneous requests show the gating and the priority. Memory acknowledges arrive after zero, one or two wait cycles, so the hold behaviour is also tested.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_F, S_PUSH_CS, S_PUSH_IP,
    S_VEC_IP, S_VEC_CS, S_POP_IP, S_POP_CS, S_POP_F
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE, K_ENTER, K_RETURN, K_SETIF, K_CLRIF, K_NOOP
  } req_kind_t;

  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_OF = 11;
  localparam int OVF_VECTOR = 4;
endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_seq_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              hw_req,
  input  logic [TYPE_W-1:0] hw_type,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              exc_req,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic              ovf_req,
  input  logic              ret_req,
  input  logic              seti_req,
  input  logic              clri_req,
  input  logic              if_flag,
  input  logic              of_flag,
  output req_kind_t         kind,
  output logic [TYPE_W-1:0] vtype
);
  always_comb begin
    kind  = K_NONE;
    vtype = '0;
    if (exc_req) begin
      kind  = K_ENTER;
      vtype = exc_type;
    end else if (sw_req) begin
      kind  = K_ENTER;
      vtype = sw_type;
    end else if (ovf_req) begin
      kind  = of_flag ? K_ENTER : K_NOOP;
      vtype = TYPE_W'(OVF_VECTOR);
    end else if (ret_req) begin
      kind = K_RETURN;
    end else if (seti_req) begin
      kind = K_SETIF;
    end else if (clri_req) begin
      kind = K_CLRIF;
    end else if (hw_req && if_flag) begin
      kind  = K_ENTER;
      vtype = hw_type;
    end
  end
endmodule

// File: rtl/irq_phys.sv
module irq_phys #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [DATA_W-1:0] seg,
  input  logic [DATA_W-1:0] off,
  output logic [ADDR_W-1:0] phys
);
  localparam int PAD = ADDR_W - DATA_W;
  logic [ADDR_W-1:0] seg_w, off_w;
  assign seg_w = {{PAD{1'b0}}, seg} << SEG_SHIFT;
  assign off_w = {{PAD{1'b0}}, off};
  assign phys  = seg_w + off_w;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int TYPE_W    = 8,
  parameter int SEG_SHIFT = 4,
  parameter logic [DATA_W-1:0] RST_CS    = 16'h1000,
  parameter logic [DATA_W-1:0] RST_IP    = 16'h0040,
  parameter logic [DATA_W-1:0] RST_SP    = 16'h0100,
  parameter logic [DATA_W-1:0] RST_FLAGS = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stk_seg,
  input  logic              hw_req,
  input  logic [TYPE_W-1:0] hw_type,
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              exc_req,
  input  logic [TYPE_W-1:0] exc_type,
  input  logic              ovf_req,
  input  logic              ret_req,
  input  logic              seti_req,
  input  logic              clri_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] ip_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] flags_o,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);
  localparam int VEC_BYTES = 2 * (DATA_W / 8);
  localparam int VEC_SH = $clog2(VEC_BYTES);

  seq_state_t        state;
  req_kind_t         kind;
  logic [TYPE_W-1:0] vtype, vec_q;
  logic [DATA_W-1:0] cs_q, ip_q, sp_q, flags_q;
  logic              done_q;
  logic [DATA_W-1:0] stk_off;
  logic [ADDR_W-1:0] stk_addr, vec_base;
  logic              push_st, vec_st;

  irq_arb #(.TYPE_W(TYPE_W)) u_arb (
    .hw_req(hw_req), .hw_type(hw_type), .sw_req(sw_req), .sw_type(sw_type),
    .exc_req(exc_req), .exc_type(exc_type), .ovf_req(ovf_req),
    .ret_req(ret_req), .seti_req(seti_req), .clri_req(clri_req),
    .if_flag(flags_q[FL_IF]), .of_flag(flags_q[FL_OF]),
    .kind(kind), .vtype(vtype)
  );

  assign push_st = (state == S_PUSH_F) || (state == S_PUSH_CS) || (state == S_PUSH_IP);
  assign vec_st  = (state == S_VEC_IP) || (state == S_VEC_CS);
  assign stk_off = push_st ? (sp_q - STEP) : sp_q;

  irq_phys #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_SHIFT(SEG_SHIFT)) u_stk (
    .seg(stk_seg), .off(stk_off), .phys(stk_addr)
  );
  irq_phys #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_SHIFT(SEG_SHIFT)) u_fetch (
    .seg(cs_q), .off(ip_q), .phys(fetch_addr)
  );

  assign vec_base = ADDR_W'(vec_q) << VEC_SH;

  always_comb begin
    mem_addr  = stk_addr;
    mem_wdata = '0;
    if (vec_st)
      mem_addr = (state == S_VEC_CS) ? vec_base + ADDR_W'(STEP) : vec_base;
    case (state)
      S_PUSH_F:  mem_wdata = flags_q;
      S_PUSH_CS: mem_wdata = cs_q;
      S_PUSH_IP: mem_wdata = ip_q;
      default:   mem_wdata = '0;
    endcase
  end

  assign mem_req = (state != S_IDLE);
  assign mem_we  = push_st;
  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign sp_o    = sp_q;
  assign flags_o = flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cs_q    <= RST_CS;
      ip_q    <= RST_IP;
      sp_q    <= RST_SP;
      flags_q <= RST_FLAGS;
      vec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          case (kind)
            K_ENTER: begin
              vec_q <= vtype;
              state <= S_PUSH_F;
            end
            K_RETURN: state <= S_POP_IP;
            K_SETIF: begin
              flags_q[FL_IF] <= 1'b1;
              done_q <= 1'b1;
            end
            K_CLRIF: begin
              flags_q[FL_IF] <= 1'b0;
              done_q <= 1'b1;
            end
            K_NOOP: done_q <= 1'b1;
            default: ;
          endcase
        end
        S_PUSH_F: if (mem_ack) begin
          sp_q <= sp_q - STEP;
          flags_q[FL_TF] <= 1'b0;
          flags_q[FL_IF] <= 1'b0;
          state <= S_PUSH_CS;
        end
        S_PUSH_CS: if (mem_ack) begin
          sp_q  <= sp_q - STEP;
          state <= S_PUSH_IP;
        end
        S_PUSH_IP: if (mem_ack) begin
          sp_q  <= sp_q - STEP;
          state <= S_VEC_IP;
        end
        S_VEC_IP: if (mem_ack) begin
          ip_q  <= mem_rdata;
          state <= S_VEC_CS;
        end
        S_VEC_CS: if (mem_ack) begin
          cs_q   <= mem_rdata;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_POP_IP: if (mem_ack) begin
          ip_q  <= mem_rdata;
          sp_q  <= sp_q + STEP;
          state <= S_POP_CS;
        end
        S_POP_CS: if (mem_ack) begin
          cs_q  <= mem_rdata;
          sp_q  <= sp_q + STEP;
          state <= S_POP_F;
        end
        S_POP_F: if (mem_ack) begin
          flags_q <= mem_rdata;
          sp_q    <= sp_q + STEP;
          done_q  <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IF_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_req,
  input logic              sw_req,
  input logic              exc_req,
  input logic              ovf_req,
  input logic              ret_req,
  input logic              seti_req,
  input logic              clri_req,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] sp_o,
  input logic [DATA_W-1:0] flags_o
);
  logic others;
  assign others = sw_req | exc_req | ovf_req | ret_req | seti_req | clri_req;

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_push_sp_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_ack |=> sp_o == $past(sp_o) - DATA_W'(2));

  p_if_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !busy && hw_req && !flags_o[IF_BIT] && !others |=> !busy && !done);
endmodule

bind irq_seq irq_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IF_BIT(irq_seq_pkg::FL_IF)) u_chk (
  .clk(clk), .rst(rst), .hw_req(hw_req), .sw_req(sw_req), .exc_req(exc_req),
  .ovf_req(ovf_req), .ret_req(ret_req), .seti_req(seti_req), .clri_req(clri_req),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_o(sp_o), .flags_o(flags_o)
);

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  logic        clk = 0;
  logic        rst;
  logic [15:0] stk_seg = 16'h2000;
  logic        hw_req, sw_req, exc_req, ovf_req, ret_req, seti_req, clri_req;
  logic [7:0]  hw_type, sw_type, exc_type;
  logic        mem_req, mem_we, mem_ack;
  logic [19:0] mem_addr, fetch_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] cs_o, ip_o, sp_o, flags_o;

  always #10 clk = ~clk;

  irq_seq u0 (
    .clk(clk), .rst(rst), .stk_seg(stk_seg),
    .hw_req(hw_req), .hw_type(hw_type), .sw_req(sw_req), .sw_type(sw_type),
    .exc_req(exc_req), .exc_type(exc_type), .ovf_req(ovf_req), .ret_req(ret_req),
    .seti_req(seti_req), .clri_req(clri_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
    .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o), .flags_o(flags_o), .fetch_addr(fetch_addr)
  );

  typedef struct { bit we; logic [19:0] a; logic [15:0] d; string tag; } acc_t;
  acc_t        expq[$];
  logic [15:0] mem [logic [19:0]];
  int          checks = 0, fails = 0, nacc = 0;
  bit          finished = 0;
  logic [15:0] m_cs, m_ip, m_sp, m_flags;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic logic [19:0] stk(input logic [15:0] off);
    return {stk_seg, 4'h0} + {4'h0, off};
  endfunction

  task automatic push_exp(input bit we, input logic [19:0] a, input logic [15:0] d, input string tag);
    acc_t e;
    e.we = we; e.a = a; e.d = d; e.tag = tag;
    expq.push_back(e);
  endtask

  // Scoreboard driver: expected accesses and model update for an entry (R3, R2, R4)
  task automatic exp_entry(input logic [7:0] t);
    logic [19:0] v;
    v = {10'h0, t, 2'b00};
    push_exp(1, stk(m_sp - 16'd2), m_flags, "R3 push flags");
    push_exp(1, stk(m_sp - 16'd4), m_cs,    "R3 push cs");
    push_exp(1, stk(m_sp - 16'd6), m_ip,    "R3 push ip");
    push_exp(0, v,         16'h0, "R2 vector ip");
    push_exp(0, v + 20'd2, 16'h0, "R2 vector cs");
    m_sp    = m_sp - 16'd6;
    m_flags = m_flags & ~16'h0300;
    m_ip    = rd(v);
    m_cs    = rd(v + 20'd2);
  endtask

  task automatic exp_return();
    push_exp(0, stk(m_sp),          16'h0, "R5 pop ip");
    push_exp(0, stk(m_sp + 16'd2),  16'h0, "R5 pop cs");
    push_exp(0, stk(m_sp + 16'd4),  16'h0, "R5 pop flags");
    m_ip    = rd(stk(m_sp));
    m_cs    = rd(stk(m_sp + 16'd2));
    m_flags = rd(stk(m_sp + 16'd4));
    m_sp    = m_sp + 16'd6;
  endtask

  // Memory responder and monitor: grants with 0..2 wait cycles, compares each access
  initial begin
    int gap;
    gap = 0;
    mem_ack = 0;
    mem_rdata = 16'h0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (gap > 0) gap--;
        else begin
          nacc++;
          if (expq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R11 unexpected access actual=%h expected=none", mem_addr);
          end else begin
            acc_t e;
            e = expq.pop_front();
            chk({e.tag, " dir"}, {31'h0, mem_we}, {31'h0, e.we});
            chk({e.tag, " addr"}, {12'h0, mem_addr}, {12'h0, e.a});
            if (e.we) chk({e.tag, " data"}, {16'h0, mem_wdata}, {16'h0, e.d});
          end
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = rd(mem_addr);
          mem_ack = 1;
          gap = nacc % 3;
        end
      end
    end
  end

  task automatic fire(input bit e, input bit s, input bit o, input bit r,
                      input bit si, input bit ci, input bit h,
                      input logic [7:0] et, input logic [7:0] st, input logic [7:0] ht);
    @(negedge clk);
    exc_req = e; sw_req = s; ovf_req = o; ret_req = r;
    seti_req = si; clri_req = ci; hw_req = h;
    exc_type = et; sw_type = st; hw_type = ht;
    @(negedge clk);
    exc_req = 0; sw_req = 0; ovf_req = 0; ret_req = 0;
    seti_req = 0; clri_req = 0; hw_req = 0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen (R10)"}, {31'h0, done}, 32'h1);
    @(negedge clk);
    chk({tag, " done one cycle (R10)"}, {31'h0, done}, 32'h0);
    chk({tag, " queue drained (R3)"}, expq.size(), 0);
  endtask

  task automatic check_ctx(input string tag);
    chk({tag, " cs"}, {16'h0, cs_o}, {16'h0, m_cs});
    chk({tag, " ip"}, {16'h0, ip_o}, {16'h0, m_ip});
    chk({tag, " sp"}, {16'h0, sp_o}, {16'h0, m_sp});
    chk({tag, " flags"}, {16'h0, flags_o}, {16'h0, m_flags});
    chk({tag, " fetch R10"}, {12'h0, fetch_addr}, {12'h0, ({m_cs, 4'h0} + {4'h0, m_ip})});
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 100000; wd++) @(negedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0;
    bit seen;
    rst = 1;
    hw_req = 0; sw_req = 0; exc_req = 0; ovf_req = 0; ret_req = 0;
    seti_req = 0; clri_req = 0; hw_type = 0; sw_type = 0; exc_type = 0;
    mem[20'h000C8] = 16'h1234; mem[20'h000CA] = 16'h3000;
    mem[20'h00010] = 16'h0444; mem[20'h00012] = 16'h4000;
    mem[20'h003FC] = 16'h0FF0; mem[20'h003FE] = 16'h5000;
    mem[20'h00000] = 16'h0010; mem[20'h00002] = 16'h6000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    m_cs = 16'h1000; m_ip = 16'h0040; m_sp = 16'h0100; m_flags = 16'h0000;
    // R1 reset state
    check_ctx("R1 reset");
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 mem_req", {31'h0, mem_req}, 0);

    // R6 software entry not gated by IF=0; type 50 vector at C8h/CAh (R2)
    exp_entry(8'd50);
    fire(0, 1, 0, 0, 0, 0, 0, 8'd0, 8'd50, 8'd0);
    wait_done("R6 sw type50");
    check_ctx("R2 sw type50");

    // Edit stacked flags to OF|IF, then return (R5)
    mem[stk(m_sp + 16'd4)] = 16'h0A00;
    exp_return();
    fire(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    wait_done("R5 return");
    check_ctx("R5 return");

    // R7 overflow check with OF=1 enters type 4; R4 clears IF keeps OF
    exp_entry(8'd4);
    fire(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    wait_done("R7 ovf taken");
    check_ctx("R7 ovf taken R4");
    exp_return();
    fire(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    wait_done("R5 return2");
    check_ctx("R5 return2");

    // R8 clear IF touches only bit 9
    m_flags = m_flags & ~16'h0200;
    fire(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    wait_done("R8 clri");
    check_ctx("R8 clri");

    // R6 device request ignored while IF=0
    a0 = nacc;
    fire(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'd255);
    seen = 0;
    repeat (6) begin
      if (busy || done) seen = 1;
      @(negedge clk);
    end
    chk("R6 hw ignored no activity", {31'h0, seen}, 0);
    chk("R6 hw ignored no access", nacc - a0, 0);
    check_ctx("R6 hw ignored");

    // R8 set IF
    m_flags = m_flags | 16'h0200;
    fire(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    wait_done("R8 seti");
    check_ctx("R8 seti");

    // R6 device request taken with IF=1, type 255 at 3FCh/3FEh (R2)
    exp_entry(8'd255);
    fire(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'd255);
    wait_done("R6 hw type255");
    check_ctx("R2 hw type255");
    mem[stk(m_sp + 16'd4)] = 16'h0300;
    exp_return();
    fire(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    wait_done("R5 return3");
    check_ctx("R5 return3 TF IF");

    // R7 overflow check with OF=0 is a no-op
    a0 = nacc;
    fire(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    wait_done("R7 ovf noop");
    chk("R7 ovf noop no access", nacc - a0, 0);
    check_ctx("R7 ovf noop");

    // R9 priority: exception beats software and device; R4 clears TF and IF
    exp_entry(8'd0);
    fire(1, 1, 0, 0, 0, 0, 1, 8'd0, 8'd50, 8'd255);
    wait_done("R9 priority exc");
    check_ctx("R9 exc type0 R4");
    chk("R4 TF IF cleared", {16'h0, flags_o & 16'h0300}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule